// File: doc/BRIEF.md
# File Register Execute Unit

This block is the execute stage of a small 8-bit accumulator machine. Each cycle it can accept one decoded instruction. An instruction names an opcode, a 7-bit address into a 128-entry file of 8-bit registers, a 3-bit bit selector and a one-bit destination flag. The unit reads the addressed register and computes a result. It writes the result either to the working accumulator (W) or back into the addressed register, and it updates the zero flag for the operations that define it.

The unit supports five operations: complement, decrement, clear a register, clear the accumulator, and a bit test that skips the next instruction when the bit is set. The skip does not redirect fetch. It annuls the next issued instruction, which then makes no writes, so that slot behaves as a no-op. The upstream fetch logic presents instructions through `issue_valid`. It watches `skip_next` only for its own accounting.

Top module: `fr_exec_unit`

## Requirements
- R1: Opcodes on `op` are 1 = bit-test-skip-if-set, 2 = complement, 3 = decrement, 4 = clear register, 5 = clear accumulator. The codes 0, 6 and 7 are no-ops and change neither W, the zero flag nor any register.
- R2: After a bit test finds the selected bit at 1, `skip_next` is 1. The next slot with `issue_valid` high is annulled: it writes nothing and leaves the zero flag alone. `skip_next` then returns to 0.
- R3: A bit test never changes W or the zero flag. When the selected bit is 0, `skip_next` stays 0 and the next instruction executes normally.
- R4: Complement with `dest` = 0 loads the bitwise inverse of the register into W, sets the zero flag when the result is 00h and clears it otherwise, and leaves the register unchanged.
- R5: Complement with `dest` = 1 writes the inverse back into the register and updates the zero flag.
- R6: Decrement writes the register value minus one to W (`dest` = 0) or to the register (`dest` = 1) and updates the zero flag. 00h wraps to FFh with the zero flag cleared. 01h gives 00h with the zero flag set.
- R7: Clear register writes 00h into the addressed register and sets the zero flag.
- R8: Clear accumulator writes 00h into W and sets the zero flag.
- R9: Synchronous reset sets W to 00h and clears the zero flag and `skip_next`. Every file register then reads as 00h.
- R10: A cycle with `issue_valid` low changes nothing. A pending skip is held until the next valid slot.
- R11: A register written by one instruction holds the new value for an instruction issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| op | input | 3 | Opcode |
| faddr | input | 7 | File register address |
| bsel | input | 3 | Bit selector for the bit test |
| dest | input | 1 | 0 = result to W, 1 = result back to the register |
| w_out | output | 8 | Working accumulator (registered) |
| zero_flag | output | 1 | Zero flag (registered) |
| skip_next | output | 1 | The next valid slot will be annulled |

## Verification
The assertions assume that reset is synchronous and that `issue_valid`, `op` and the operand fields hold known values at every rising edge. They also assume that every cycle with `issue_valid` high is one instruction slot. The bench therefore changes inputs only on falling edges. It lowers `issue_valid` between tasks, except where it issues instructions back to back on purpose. It reads register contents only through complement-to-W, taking the inverse of W as the register value. It loads chosen values only with the supported operations.

// File: rtl/fr_exec_pkg.sv
package fr_exec_pkg;
  localparam logic [2:0] OPC_NOP  = 3'd0;
  localparam logic [2:0] OPC_BTSS = 3'd1;
  localparam logic [2:0] OPC_COMP = 3'd2;
  localparam logic [2:0] OPC_DEC  = 3'd3;
  localparam logic [2:0] OPC_CLRF = 3'd4;
  localparam logic [2:0] OPC_CLRW = 3'd5;
endpackage

// File: rtl/fr_regfile.sv
module fr_regfile #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written_q;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // per-entry flag makes a never-written entry read as zero after reset
  always_ff @(posedge clk) begin
    if (rst)     written_q <= '0;
    else if (we) written_q[waddr] <= 1'b1;
  end

  assign rdata = written_q[raddr] ? mem[raddr] : '0;

  p_written_after_we_r11: assert property (@(posedge clk) disable iff (rst)
    we |=> written_q[$past(waddr)]);
endmodule

// File: rtl/fr_alu.sv
module fr_alu
  import fr_exec_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = $clog2(DW)
) (
  input  logic [2:0]    op,
  input  logic          dest,
  input  logic [DW-1:0] operand,
  input  logic [BW-1:0] bsel,
  output logic [DW-1:0] res,
  output logic          res_valid,
  output logic          res_to_file,
  output logic          z_valid,
  output logic          z_val,
  output logic          skip_req
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    res         = '0;
    res_valid   = 1'b0;
    res_to_file = 1'b0;
    z_valid     = 1'b0;
    skip_req    = 1'b0;
    unique case (op)
      OPC_BTSS: skip_req = operand[bsel];
      OPC_COMP: begin
        res = ~operand; res_valid = 1'b1; res_to_file = dest; z_valid = 1'b1;
      end
      OPC_DEC: begin
        res = operand - ONE; res_valid = 1'b1; res_to_file = dest; z_valid = 1'b1;
      end
      OPC_CLRF: begin
        res_valid = 1'b1; res_to_file = 1'b1; z_valid = 1'b1;
      end
      OPC_CLRW: begin
        res_valid = 1'b1; z_valid = 1'b1;
      end
      default: ;
    endcase
  end

  assign z_val = (res == '0);

  // R6: wrap from zero yields all ones with zero flag clear
  always_comb begin
    if (op == OPC_DEC && operand == '0)
      p_dec_wrap_r6: assert (res == '1 && !z_val);
  end
endmodule

// File: rtl/fr_exec_unit.sv
module fr_exec_unit
  import fr_exec_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int BW    = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_valid,
  input  logic [2:0]    op,
  input  logic [AW-1:0] faddr,
  input  logic [BW-1:0] bsel,
  input  logic          dest,
  output logic [DW-1:0] w_out,
  output logic          zero_flag,
  output logic          skip_next
);
  logic [DW-1:0] rd_data, res;
  logic res_valid, res_to_file, z_valid, z_val, skip_req;
  logic exec, file_we, w_we;
  logic [DW-1:0] w_q;
  logic z_q, skip_q;

  fr_regfile #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rf (
    .clk(clk), .rst(rst), .we(file_we), .waddr(faddr), .wdata(res),
    .raddr(faddr), .rdata(rd_data)
  );

  fr_alu #(.DW(DW), .BW(BW)) u_alu (
    .op(op), .dest(dest), .operand(rd_data), .bsel(bsel),
    .res(res), .res_valid(res_valid), .res_to_file(res_to_file),
    .z_valid(z_valid), .z_val(z_val), .skip_req(skip_req)
  );

  // a slot executes only when valid and not annulled by a pending skip
  assign exec    = issue_valid && !skip_q;
  assign file_we = exec && res_valid && res_to_file;
  assign w_we    = exec && res_valid && !res_to_file;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q    <= '0;
      z_q    <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      if (w_we)          w_q    <= res;
      if (exec && z_valid) z_q  <= z_val;
      if (issue_valid)   skip_q <= exec && skip_req;
    end
  end

  assign w_out     = w_q;
  assign zero_flag = z_q;
  assign skip_next = skip_q;

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (w_q == '0 && !z_q && !skip_q));

  p_skip_one_slot_r2: assert property (@(posedge clk) disable iff (rst)
    (skip_q && issue_valid) |=> !skip_q);

  p_annul_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    (skip_q && issue_valid) |=> ($stable(w_q) && $stable(z_q)));

  p_btss_keeps_state_r3: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OPC_BTSS) |=> ($stable(w_q) && $stable(z_q)));

  p_clrw_result_r8: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OPC_CLRW) |=> (w_q == '0 && z_q));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> ($stable(w_q) && $stable(z_q) && $stable(skip_q)));
endmodule

// File: tb/tb_fr_exec_unit.sv
module tb_fr_exec_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue_valid = 1'b0;
  logic [2:0] op = 3'd0;
  logic [6:0] faddr = '0;
  logic [2:0] bsel = '0;
  logic       dest = 1'b0;
  logic [7:0] w_out;
  logic       zero_flag, skip_next;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fr_exec_unit dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .op(op), .faddr(faddr),
    .bsel(bsel), .dest(dest), .w_out(w_out), .zero_flag(zero_flag),
    .skip_next(skip_next)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called just after a falling edge; results visible at the next falling edge
  task automatic issue(input logic [2:0] o, input logic [6:0] a,
                       input logic [2:0] b, input logic d);
    issue_valid = 1'b1; op = o; faddr = a; bsel = b; dest = d;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_f(input logic [6:0] a, output logic [7:0] v);
    issue(3'd2, a, 3'd0, 1'b0);
    v = ~w_out;
  endtask

  task automatic set_f(input logic [6:0] a, input logic [7:0] v);
    issue(3'd4, a, 3'd0, 1'b1);
    issue(3'd2, a, 3'd0, 1'b1);
    for (int i = 0; i < 255 - int'(v); i++) issue(3'd3, a, 3'd0, 1'b1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R9 w", w_out, 0);
    check("R9 z", zero_flag, 0);
    check("R9 skip", skip_next, 0);
    read_f(7'd5, v);   check("R9 f5", v, 0);
    read_f(7'd127, v); check("R9 f127", v, 0);
  endtask

  task automatic t_comf();
    logic [7:0] v;
    set_f(7'd10, 8'h5A);
    issue(3'd2, 7'd10, 3'd0, 1'b0);
    check("R4 w", w_out, 8'hA5);
    check("R4 z", zero_flag, 0);
    read_f(7'd10, v); check("R4 f kept", v, 8'h5A);
    set_f(7'd11, 8'hFF);
    issue(3'd2, 7'd11, 3'd0, 1'b1);
    check("R5 z", zero_flag, 1);
    read_f(7'd11, v); check("R5 f", v, 8'h00);
  endtask

  task automatic t_decf();
    logic [7:0] v;
    issue(3'd4, 7'd20, 3'd0, 1'b1);
    issue(3'd3, 7'd20, 3'd0, 1'b0);
    check("R6 wrap w", w_out, 8'hFF);
    check("R6 wrap z", zero_flag, 0);
    read_f(7'd20, v); check("R6 f kept", v, 8'h00);
    set_f(7'd21, 8'h01);
    issue(3'd3, 7'd21, 3'd0, 1'b1);
    check("R6 z set", zero_flag, 1);
    read_f(7'd21, v); check("R6 f", v, 8'h00);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    set_f(7'd30, 8'h33);
    issue(3'd4, 7'd30, 3'd0, 1'b1);
    check("R7 z", zero_flag, 1);
    read_f(7'd30, v); check("R7 f", v, 0);
    set_f(7'd31, 8'hF0);
    issue(3'd2, 7'd31, 3'd0, 1'b0);
    issue(3'd5, 7'd0, 3'd0, 1'b0);
    check("R8 w", w_out, 0);
    check("R8 z", zero_flag, 1);
  endtask

  task automatic t_skip();
    logic [7:0] v;
    set_f(7'd40, 8'h80);
    set_f(7'd41, 8'h44);
    issue(3'd2, 7'd41, 3'd0, 1'b0);   // W = BB, Z = 0
    issue(3'd1, 7'd40, 3'd7, 1'b0);
    check("R2 skip set", skip_next, 1);
    check("R3 w kept", w_out, 8'hBB);
    check("R3 z kept", zero_flag, 0);
    idle(2);
    check("R10 skip held", skip_next, 1);
    issue(3'd4, 7'd41, 3'd0, 1'b1);   // annulled
    check("R2 skip clear", skip_next, 0);
    check("R2 z kept", zero_flag, 0);
    read_f(7'd41, v); check("R2 f kept", v, 8'h44);
    issue(3'd1, 7'd40, 3'd6, 1'b0);
    check("R3 no skip", skip_next, 0);
    issue(3'd5, 7'd0, 3'd0, 1'b0);
    check("R3 next runs", zero_flag, 1);
  endtask

  task automatic t_nop_idle();
    logic [7:0] v;
    set_f(7'd50, 8'h0F);
    issue(3'd2, 7'd50, 3'd0, 1'b0);   // W = F0, Z = 0
    issue(3'd6, 7'd50, 3'd0, 1'b1);
    issue(3'd7, 7'd50, 3'd0, 1'b0);
    issue(3'd0, 7'd50, 3'd0, 1'b1);
    check("R1 w", w_out, 8'hF0);
    check("R1 z", zero_flag, 0);
    read_f(7'd50, v); check("R1 f", v, 8'h0F);
    op = 3'd4; faddr = 7'd50; dest = 1'b1;   // issue_valid stays low
    idle(2);
    read_f(7'd50, v); check("R10 f", v, 8'h0F);
  endtask

  task automatic t_back2back();
    logic [7:0] v;
    set_f(7'd60, 8'h05);
    issue(3'd3, 7'd60, 3'd0, 1'b1);
    issue(3'd3, 7'd60, 3'd0, 1'b1);
    issue(3'd2, 7'd60, 3'd0, 1'b0);
    v = ~w_out;
    check("R11 chain", v, 8'h03);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_comf();
    t_decf();
    t_clear();
    t_skip();
    t_nop_idle();
    t_back2back();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule